// File: doc/BRIEF.md
# Register-Write Batch Builder

This block assembles a packed stream of register-write instructions in a local dword store, ready for a command engine to fetch and replay. Requests arrive one at a time on a valid/ready port. Each request carries a 20-bit register offset, a 32-bit value and a flag that selects a plain write or an indexed (auto-increment) write. When indexed writes target the same register one after another, the block folds them into one counted instruction. It does not emit a fresh header for each of them.

A commit request closes the batch. The block zero-fills the stream up to the next 64-byte boundary and pulses a done strobe with the stream length in bytes. The stream always starts at dword 0. The block then clears itself for the next batch. A one-cycle-latency read port exposes any dword of the store, so a consumer can copy the stream out or a test can inspect it.

Top module: `regwr_batcher`

## Requirements
- R1: A plain write (req_indexed=0) places the value at the current write position and a header at the next dword: bits 31:24 = 0x01, bits 23:20 = 0xF, bits 19:0 = offset. The position advances by 2 and no alignment is applied.
- R2: An indexed write whose offset equals the open indexed instruction's offset stores the value at the write position, advances it by 1, and rewrites that instruction's first dword (its count) with the count plus one.
- R3: An indexed write with no matching open instruction rounds the position up to even. If the position was odd, it zeroes the skipped dword. It then writes count 1, a header (bits 31:24 = 0x09, bits 23:20 = 0, bits 19:0 = offset) and the value. The write position ends 3 past the aligned start.
- R4: Whenever an indexed write leaves the write position odd, the dword at that position is written with zero.
- R5: A plain write closes any open indexed instruction, so a later indexed write to the same offset starts a new instruction.
- R6: The store holds DEPTH (2048) dwords. A request that does not fit is still accepted with ready high, writes nothing, and sets `overflow`. A plain write fits when position+2 ≤ DEPTH. A matching indexed write fits when position < DEPTH. A new indexed instruction fits when the even start + 3 ≤ DEPTH. `overflow` stays set until a commit completes.
- R7: A commit of a non-empty batch writes zero into every dword from the write position up to the next multiple of 16 dwords. It then raises `commit_done` for exactly one cycle with `commit_len` = that boundary × 4 bytes.
- R8: A commit while the write position is 0 produces no done pulse and changes nothing.
- R9: Completing a commit clears the write position, the open instruction and `overflow`, so the next batch starts at dword 0.
- R10: `req_ready` is low in the first cycle of a new indexed instruction, so a request takes two cycles. It is also low while padding and whenever `commit_req` is high in the idle state, because commit takes priority.
- R11: After reset `req_ready` is high, and `commit_done` and `overflow` are low.
- R12: `rd_data` returns the dword at `rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| req_indexed | input | 1 | 1 = indexed write, 0 = plain write |
| req_offset | input | 20 | Register offset |
| req_value | input | 32 | Value to write |
| commit_req | input | 1 | Close and pad the batch (sampled when idle) |
| commit_done | output | 1 | One-cycle strobe at end of commit |
| commit_len | output | 14 | Stream length in bytes, held after the strobe |
| overflow | output | 1 | A request was dropped for lack of room |
| rd_addr | input | 11 | Store read address |
| rd_data | output | 32 | Store read data, one cycle later |

## Verification
The bench targets the places where the merge logic can go wrong. One is an indexed write that follows a plain write to the same offset: a design that kept the instruction open would bump a stale count and not start a new instruction. Another is a new indexed instruction that starts at an odd position: a design that forgot the skipped dword or the alignment would leave junk or misplace the header. A third is padding after an odd-length run, which a design could leave unwritten. At the capacity edge, a header that would straddle the end must be refused while a plain write that exactly fills the store must still land, and a commit at an exact 64-byte boundary must finish with no pad cycles. An empty commit must stay silent. Each batch is read back in full, so a wrong count rewrite, a shifted field or a missing zero shows up as a mismatched dword.

// File: rtl/wbb_pkg.sv
package wbb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR2 = 2'd1,
        ST_PAD  = 2'd2
    } wbb_state_e;

    localparam int          OFF_W      = 20;
    localparam logic [7:0]  OPC_PLAIN  = 8'h01;
    localparam logic [7:0]  OPC_INDEX  = 8'h09;
    localparam logic [3:0]  BE_ALL     = 4'hF;
    localparam logic [3:0]  BE_NONE    = 4'h0;

    function automatic logic [31:0] make_hdr(input logic [7:0] opc,
                                             input logic [3:0] be,
                                             input logic [OFF_W-1:0] off);
        return {opc, be, off};
    endfunction

endpackage

// File: rtl/wbb_round.sv
module wbb_round #(
    parameter int W  = 12,
    parameter int SH = 1
) (
    input  logic [W-1:0] val,
    output logic [W:0]   up
);
    localparam logic [W:0] ADD  = (W+1)'((1 << SH) - 1);
    localparam logic [W:0] KEEP = ~ADD;

    logic [W:0] sum;

    always_comb begin
        sum = {1'b0, val} + ADD;
        up  = sum & KEEP;
    end
endmodule

// File: rtl/wbb_store.sv
module wbb_store #(
    parameter int DEPTH = 2048,
    parameter int NPORT = 3,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic [NPORT-1:0]           we,
    input  logic [NPORT-1:0][AW-1:0]   wa,
    input  logic [NPORT-1:0][31:0]     wd,
    input  logic [AW-1:0]              rd_addr,
    output logic [31:0]                rd_data
);
    logic [31:0] mem [DEPTH];

    // Higher-numbered ports win on an address collision.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (we[p]) mem[wa[p]] <= wd[p];
        end
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/regwr_batcher.sv
module regwr_batcher
    import wbb_pkg::*;
#(
    parameter int DEPTH   = 2048,
    parameter int LINE_DW = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1,
    localparam int LEN_W  = PW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_indexed,
    input  logic [19:0]      req_offset,
    input  logic [31:0]      req_value,
    input  logic             commit_req,
    output logic             commit_done,
    output logic [LEN_W-1:0] commit_len,
    output logic             overflow,
    input  logic [AW-1:0]    rd_addr,
    output logic [31:0]      rd_data
);
    localparam int         NPORT   = 3;
    localparam int         LINE_SH = $clog2(LINE_DW);
    localparam logic [PW:0] CAP    = (PW+1)'(DEPTH);

    typedef struct packed {
        wbb_state_e       st;
        logic [PW-1:0]    pos;
        logic [PW-1:0]    cur;
        logic [PW-1:0]    cnt;
        logic [PW-1:0]    pad;
        logic [PW-1:0]    tail;
        logic [OFF_W-1:0] off;
        logic             open;
        logic             ovf;
        logic             done;
        logic [LEN_W-1:0] len;
    } regs_t;

    regs_t r_q, r_d;

    logic [NPORT-1:0]          we;
    logic [NPORT-1:0][AW-1:0]  wa;
    logic [NPORT-1:0][31:0]    wd;

    logic [PW:0]   pos_x;
    logic [PW:0]   even_x;
    logic [PW:0]   line_x;
    logic [AW-1:0] pos_a;
    logic [AW-1:0] even_a;
    logic          match;
    logic          fit_plain;
    logic          fit_same;
    logic          fit_new;
    logic          pad_next;

    wbb_round #(.W(PW), .SH(1)) u_even (
        .val (r_q.pos),
        .up  (even_x)
    );

    wbb_round #(.W(PW), .SH(LINE_SH)) u_line (
        .val (r_q.pos),
        .up  (line_x)
    );

    wbb_store #(.DEPTH(DEPTH), .NPORT(NPORT)) u_store (
        .clk     (clk),
        .we      (we),
        .wa      (wa),
        .wd      (wd),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        pos_x     = {1'b0, r_q.pos};
        pos_a     = r_q.pos[AW-1:0];
        even_a    = even_x[AW-1:0];
        match     = r_q.open && req_indexed && (req_offset == r_q.off);
        fit_plain = (pos_x + (PW+1)'(2)) <= CAP;
        fit_same  = pos_x < CAP;
        fit_new   = (even_x + (PW+1)'(3)) <= CAP;
        pad_next  = !r_q.pos[0] && ((pos_x + (PW+1)'(1)) < CAP);

        r_d       = r_q;
        r_d.done  = 1'b0;
        we        = '0;
        wa        = '0;
        wd        = '0;
        req_ready = 1'b0;

        unique case (r_q.st)
            ST_IDLE: begin
                req_ready = !commit_req &&
                            !(req_valid && req_indexed && !match && fit_new);
                if (commit_req) begin
                    if (r_q.pos != '0) begin
                        if (line_x == pos_x) begin
                            r_d.done = 1'b1;
                            r_d.len  = {r_q.pos, 2'b00};
                            r_d.pos  = '0;
                            r_d.cur  = '0;
                            r_d.cnt  = '0;
                            r_d.open = 1'b0;
                            r_d.ovf  = 1'b0;
                        end else begin
                            r_d.st   = ST_PAD;
                            r_d.pad  = r_q.pos;
                            r_d.tail = line_x[PW-1:0];
                        end
                    end
                end else if (req_valid) begin
                    if (!req_indexed) begin
                        if (fit_plain) begin
                            we[0]    = 1'b1;
                            wa[0]    = pos_a;
                            wd[0]    = req_value;
                            we[1]    = 1'b1;
                            wa[1]    = pos_a + AW'(1);
                            wd[1]    = make_hdr(OPC_PLAIN, BE_ALL, req_offset);
                            r_d.pos  = r_q.pos + PW'(2);
                            r_d.cur  = r_q.pos;
                            r_d.open = 1'b0;
                        end else begin
                            r_d.ovf  = 1'b1;
                        end
                    end else if (match) begin
                        if (fit_same) begin
                            we[0]   = 1'b1;
                            wa[0]   = pos_a;
                            wd[0]   = req_value;
                            we[1]   = 1'b1;
                            wa[1]   = r_q.cur[AW-1:0];
                            wd[1]   = 32'(r_q.cnt + PW'(1));
                            we[2]   = pad_next;
                            wa[2]   = pos_a + AW'(1);
                            wd[2]   = '0;
                            r_d.pos = r_q.pos + PW'(1);
                            r_d.cnt = r_q.cnt + PW'(1);
                        end else begin
                            r_d.ovf = 1'b1;
                        end
                    end else if (fit_new) begin
                        we[0]    = 1'b1;
                        wa[0]    = even_a;
                        wd[0]    = 32'd1;
                        we[1]    = 1'b1;
                        wa[1]    = even_a + AW'(1);
                        wd[1]    = make_hdr(OPC_INDEX, BE_NONE, req_offset);
                        we[2]    = r_q.pos[0];
                        wa[2]    = pos_a;
                        wd[2]    = '0;
                        r_d.pos  = even_x[PW-1:0] + PW'(2);
                        r_d.cur  = even_x[PW-1:0];
                        r_d.cnt  = PW'(1);
                        r_d.off  = req_offset;
                        r_d.open = 1'b1;
                        r_d.st   = ST_HDR2;
                    end else begin
                        r_d.ovf  = 1'b1;
                    end
                end
            end
            ST_HDR2: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    we[0]   = 1'b1;
                    wa[0]   = pos_a;
                    wd[0]   = req_value;
                    we[2]   = 1'b1;
                    wa[2]   = pos_a + AW'(1);
                    wd[2]   = '0;
                    r_d.pos = r_q.pos + PW'(1);
                    r_d.st  = ST_IDLE;
                end
            end
            ST_PAD: begin
                we[0]   = 1'b1;
                wa[0]   = r_q.pad[AW-1:0];
                wd[0]   = '0;
                r_d.pad = r_q.pad + PW'(1);
                if ((r_q.pad + PW'(1)) == r_q.tail) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.len  = {r_q.tail, 2'b00};
                    r_d.pos  = '0;
                    r_d.cur  = '0;
                    r_d.cnt  = '0;
                    r_d.open = 1'b0;
                    r_d.ovf  = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign commit_done = r_q.done;
    assign commit_len  = r_q.len;
    assign overflow    = r_q.ovf;

endmodule

// File: rtl/regwr_batcher_chk.sv
module regwr_batcher_chk #(
    parameter int DEPTH = 2048,
    parameter int PW    = 12,
    parameter int LEN_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             commit_done,
    input logic [LEN_W-1:0] commit_len,
    input logic             overflow,
    input logic [PW-1:0]    pos,
    input logic             in_pad,
    input logic             in_hdr2
);
    // R7: done strobe lasts one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |=> !commit_done);

    // R7: reported length lands on a 64-byte boundary
    a_r7_len_line: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> (commit_len[5:0] == 6'd0));

    // R9: a finished commit leaves no overflow behind
    a_r9_done_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        commit_done |-> !overflow);

    // R6: overflow holds until a commit completes
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> (overflow || commit_done));

    // R6: write position never passes capacity
    a_r6_pos_cap: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pos) <= DEPTH);

    // R10: no request taken while padding
    a_r10_pad_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        in_pad |-> !req_ready);

    // R3: a new indexed instruction starts on an even dword
    a_r3_hdr_even: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr2 |-> !pos[0]);
endmodule

bind regwr_batcher regwr_batcher_chk #(
    .DEPTH (DEPTH),
    .PW    (PW),
    .LEN_W (LEN_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .commit_done (commit_done),
    .commit_len  (commit_len),
    .overflow    (overflow),
    .pos         (r_q.pos),
    .in_pad      (r_q.st == wbb_pkg::ST_PAD),
    .in_hdr2     (r_q.st == wbb_pkg::ST_HDR2)
);

// File: tb/regwr_batcher_tb_top.sv
`timescale 1ns/1ps
module regwr_batcher_tb_top;
    localparam int DEPTH = 2048;

    typedef struct packed {
        logic [1:0]  kind;   // 0 plain, 1 indexed, 2 commit
        logic [19:0] off;
        logic [31:0] val;    // for commit: expected byte length
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 20'h00100, 32'hA0000001},
        '{2'd1, 20'h00100, 32'hA0000002},
        '{2'd1, 20'h00100, 32'hA0000003},
        '{2'd0, 20'h00200, 32'hD0000001},
        '{2'd1, 20'h00200, 32'hE0000001},
        '{2'd1, 20'h00300, 32'hF0000001},
        '{2'd2, 20'h0,     32'd64},
        '{2'd0, 20'h00010, 32'hB0000001},
        '{2'd2, 20'h0,     32'd64},
        '{2'd1, 20'h00040, 32'hC0000001},
        '{2'd1, 20'h00040, 32'hC0000002},
        '{2'd0, 20'h00044, 32'hC0000003},
        '{2'd2, 20'h0,     32'd64},
        '{2'd1, 20'h00050, 32'h60000001},
        '{2'd0, 20'h00051, 32'h60000002},
        '{2'd1, 20'h00052, 32'h60000003},
        '{2'd1, 20'h00052, 32'h60000004},
        '{2'd2, 20'h0,     32'd64}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_indexed = 1'b0;
    logic [19:0] req_offset = '0;
    logic [31:0] req_value = '0;
    logic        commit_req = 1'b0;
    logic        commit_done;
    logic [13:0] commit_len;
    logic        overflow;
    logic [10:0] rd_addr = '0;
    logic [31:0] rd_data;

    int nchk = 0;
    int nerr = 0;

    logic [31:0] em [DEPTH];
    int   mpos = 0, mcur = 0, mcnt = 0;
    bit   mopen = 1'b0, movf = 1'b0;
    logic [19:0] moff = '0;

    always #2.5 clk = ~clk;

    regwr_batcher dut_i (
        .clk, .rst_n, .req_valid, .req_ready, .req_indexed, .req_offset,
        .req_value, .commit_req, .commit_done, .commit_len, .overflow,
        .rd_addr, .rd_data
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic m_req(bit idx, logic [19:0] off, logic [31:0] val);
        if (!idx) begin
            if (mpos + 2 <= DEPTH) begin
                em[mpos] = val;
                em[mpos+1] = {8'h01, 4'hF, off};
                mpos += 2;
                mopen = 1'b0;
            end else movf = 1'b1;
        end else if (mopen && off == moff) begin
            if (mpos < DEPTH) begin
                em[mpos] = val;
                mcnt++;
                em[mcur] = 32'(mcnt);
                if (mpos % 2 == 0 && mpos + 1 < DEPTH) em[mpos+1] = '0;
                mpos++;
            end else movf = 1'b1;
        end else begin
            int b = mpos + (mpos % 2);
            if (b + 3 <= DEPTH) begin
                if (mpos % 2 == 1) em[mpos] = '0;
                em[b] = 32'd1;
                em[b+1] = {8'h09, 4'h0, off};
                em[b+2] = val;
                em[b+3] = '0;
                mpos = b + 3; mcur = b; mcnt = 1; moff = off; mopen = 1'b1;
            end else movf = 1'b1;
        end
    endtask

    task automatic send(bit idx, logic [19:0] off, logic [31:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_indexed = idx; req_offset = off; req_value = val;
        #0.1;
        while (!req_ready) begin @(negedge clk); #0.1; end
        @(posedge clk); #0.1;
        req_valid = 1'b0;
        m_req(idx, off, val);
    endtask

    task automatic rd(int a, output logic [31:0] d);
        @(negedge clk); rd_addr = 11'(a);
        @(negedge clk); d = rd_data;
    endtask

    task automatic do_commit(int exp_len);
        int tail = ((mpos + 15) / 16) * 16;
        int cnt = 0;
        logic [31:0] d;
        @(negedge clk); commit_req = 1'b1;
        @(negedge clk); commit_req = 1'b0;
        if (mpos == 0) begin
            for (int i = 0; i < 10; i++) begin
                check("R8 empty commit no done", 32'(commit_done), 32'd0);
                @(negedge clk);
            end
            return;
        end
        if (tail != mpos) check("R10 ready low while padding", 32'(req_ready), 32'd0);
        for (int i = mpos; i < tail; i++) em[i] = '0;
        while (!commit_done && cnt < 200) begin @(negedge clk); cnt++; end
        check("R7 done seen", 32'(commit_done), 32'd1);
        check("R7 len model", 32'(commit_len), 32'(tail * 4));
        if (exp_len >= 0) check("R7 len table", 32'(commit_len), 32'(exp_len));
        @(negedge clk);
        check("R7 done one cycle", 32'(commit_done), 32'd0);
        check("R9 overflow cleared", 32'(overflow), 32'd0);
        for (int i = 0; i < tail; i++) begin
            rd(i, d);
            check("R1/R2/R3/R4/R5/R12 content", d, em[i]);
        end
        mpos = 0; mcur = 0; mcnt = 0; mopen = 1'b0; movf = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 ready after reset", 32'(req_ready), 32'd1);
        check("R11 done low after reset", 32'(commit_done), 32'd0);
        check("R11 overflow low after reset", 32'(overflow), 32'd0);

        do_commit(-1); // R8 empty batch

        for (int v = 0; v < NV; v++) begin
            if (VEC[v].kind == 2'd2) do_commit(int'(VEC[v].val));
            else send(VEC[v].kind[0], VEC[v].off, VEC[v].val);
        end
        do_commit(-1); // R8 empty right after a commit

        // R10: new indexed instruction stalls one cycle
        @(negedge clk);
        req_valid = 1'b1; req_indexed = 1'b1; req_offset = 20'h00777; req_value = 32'h77;
        #0.1;
        check("R10 ready low on header cycle", 32'(req_ready), 32'd0);
        @(negedge clk); #0.1;
        check("R10 ready high on value cycle", 32'(req_ready), 32'd1);
        @(posedge clk); #0.1;
        req_valid = 1'b0;
        m_req(1'b1, 20'h00777, 32'h77);
        // R10: commit beats a pending request
        @(negedge clk);
        commit_req = 1'b1; req_valid = 1'b1; req_indexed = 1'b0; #0.1;
        check("R10 commit wins", 32'(req_ready), 32'd0);
        commit_req = 1'b0; req_valid = 1'b0;
        do_commit(64);

        // R7: exactly aligned batch finishes without padding
        for (int i = 0; i < 8; i++) send(1'b0, 20'(i), 32'h1000 + i);
        do_commit(64);
        for (int i = 0; i < 9; i++) send(1'b0, 20'(i + 32), 32'h2000 + i);
        do_commit(128);

        // R6: capacity edge
        for (int i = 0; i < DEPTH/2 - 1; i++) send(1'b0, 20'(i), 32'h30000 + i);
        send(1'b1, 20'h00ABC, 32'hDEAD);
        @(negedge clk);
        check("R6 header that cannot fit sets overflow", 32'(overflow), 32'd1);
        send(1'b0, 20'h00FFF, 32'hBEEF);
        check("R6 plain write filling last slots", 32'(mpos), 32'(DEPTH));
        send(1'b0, 20'h00EEE, 32'hBAD0);
        @(negedge clk);
        check("R6 overflow sticky", 32'(overflow), 32'd1);
        do_commit(8192);

        finish_run();
    end
endmodule